// File: doc/BRIEF.md
# Linked-List Memory-to-Stream Transfer Engine

This block walks a chain of transfer descriptors kept in memory and plays the bytes that each descriptor names out on an 8-bit AXI4-Stream master port. Software writes the byte address of the first descriptor onto `head_ptr_i` and pulses `start_i`. The engine then loads each descriptor one word at a time over a single-outstanding word-addressed memory port. It sends the payload bytes and writes a finished status word back over the first word of the descriptor. Then it jumps to the next descriptor through the 64-bit link pointer.

A descriptor takes eight consecutive 32-bit words. The word offsets are: 0 status, 1 control, 2 and 3 source address (low word then high word), 4 and 5 destination address (not used by this memory-to-stream engine), 6 and 7 link pointer (low word then high word). The walk ends only when a fetched status word already carries its completion flag. An error response from memory ends the walk at once and raises a sticky error flag.

Top module: `sg_chain_engine`

## Requirements
- R1: After reset, `idle_o` is 1, `busy_o` is 0, `error_o` is 0, `m_tvalid_o` is 0 and `mem_req_o` is 0.
- R2: For a descriptor at byte address P, the engine issues eight reads (`mem_we_o`=0) at word addresses P>>2, P>>2+1, … P>>2+7, in that order, before it moves any data for that descriptor. The low two bits of P are ignored.
- R3: If bit 31 of a fetched status word is 1, the engine sends no bytes and writes nothing to memory, and it returns to idle.
- R4: Bits [25:0] of the control word hold N-1, and exactly N bytes are sent for that descriptor. Control bits 31 and 29:26 are ignored.
- R5: Bytes are read from source byte address S upward. Byte address A comes from word A>>2, lane A[1:0], where lane k is bits [8k+7:8k]. Consecutive bytes cross word boundaries without gaps.
- R6: When control bit 30 is 1, `m_tlast_o` is 1 on the descriptor's final byte and 0 on its other bytes. When control bit 30 is 0, `m_tlast_o` is 0 on all of its bytes.
- R7: A byte is transferred only in a cycle where `m_tvalid_o` and `m_tready_i` are both 1. While `m_tvalid_o` is 1 and `m_tready_i` is 0, in the next cycle `m_tvalid_o` stays 1 and `m_tdata_o` and `m_tlast_o` do not change.
- R8: After the final byte of a descriptor, the engine writes one word to the descriptor's status address. The word is 0x80000000 OR the number of bytes sent: bit 31 is 1, bits 30:27 are 0, and bits 26:0 hold the count. No other memory writes occur.
- R9: After the status write-back, the next descriptor is fetched from the full 64-bit pointer {word 7, word 6}, including a nonzero upper word.
- R10: A `start_i` pulse while `busy_o` is 1 is ignored. The running chain is unchanged and the descriptor named by the ignored pointer is never touched.
- R11: A response with `mem_err_i`=1 ends the walk at once and returns to idle with `error_o`=1. `error_o` stays 1 until the next accepted start, which clears it.
- R12: `mem_req_o`, `mem_addr_o`, `mem_we_o` and `mem_wdata_o` hold steady from the request until the cycle that `mem_resp_i` is 1. Only one request is outstanding at a time.
- R13: `busy_o` is the inverse of `idle_o`. `busy_o` rises in the cycle after an accepted start and stays 1 until the walk ends. While idle, neither a memory request nor stream data is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins a walk |
| head_ptr_i | input | 64 | Byte address of the first descriptor |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_addr_o | output | 62 | Word address of the access |
| mem_wdata_o | output | 32 | Write data |
| mem_resp_i | input | 1 | One-cycle response that ends the current request |
| mem_err_i | input | 1 | Response carries an error (valid with `mem_resp_i`) |
| mem_rdata_i | input | 32 | Read data (valid with `mem_resp_i`) |
| m_tvalid_o | output | 1 | Stream byte valid |
| m_tready_i | input | 1 | Stream sink ready |
| m_tdata_o | output | 8 | Stream byte |
| m_tlast_o | output | 1 | Last byte of a packet |
| busy_o | output | 1 | Walk in progress |
| idle_o | output | 1 | No walk in progress |
| error_o | output | 1 | Sticky memory error flag |

## Verification
The assertions assume a memory responder that pulses `mem_resp_i` for a single cycle, and only while `mem_req_o` is high. The bench's responder waits zero to two cycles after seeing a request. It drops the response line at the next sample and skips one sample before serving the next request, so no response is ever duplicated or unrequested. The stall-hold checks assume the sink only toggles `m_tready_i` at arbitrary times. The bench drives it from a 70/30 random pattern and never needs `m_tvalid_o` to depend on it. Descriptor chains in the bench are acyclic and never overlap their payload buffers, which keeps the expected-value walk in the bench well defined.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int WORD_W     = 32;
  localparam int BYTE_W     = 8;
  localparam int LANES      = WORD_W / BYTE_W;
  localparam int LANE_W     = $clog2(LANES);
  localparam int DESC_WORDS = 8;
  localparam int IDX_W      = $clog2(DESC_WORDS);

  // word offsets inside a descriptor; the fetch order follows them
  localparam logic [IDX_W-1:0] IDX_STATUS  = 3'd0;
  localparam logic [IDX_W-1:0] IDX_CTRL    = 3'd1;
  localparam logic [IDX_W-1:0] IDX_SRC_LO  = 3'd2;
  localparam logic [IDX_W-1:0] IDX_LINK_LO = 3'd6;
  localparam logic [IDX_W-1:0] IDX_LAST    = 3'd7;

  localparam int DONE_BIT = 31;
  localparam int EOP_BIT  = 30;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_DECIDE,
    S_READ,
    S_SEND,
    S_WBACK
  } walk_state_t;
endpackage

// File: rtl/sg_desc_store.sv
module sg_desc_store
  import sg_pkg::*;
#(
  parameter int PTR_W = 64,
  parameter int LEN_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              done_o,
  output logic              eop_o,
  output logic [LEN_W-1:0]  len_m1_o,
  output logic [PTR_W-1:0]  src_addr_o,
  output logic [PTR_W-1:0]  link_addr_o
);
  localparam int PTR_WORDS = PTR_W / WORD_W;

  logic             done_q, eop_q;
  logic [LEN_W-1:0] len_q;
  logic [PTR_W-1:0] src_q, link_q;
  logic             status_en, ctrl_en;

  assign status_en = wr_en_i && (wr_idx_i == IDX_STATUS);
  assign ctrl_en   = wr_en_i && (wr_idx_i == IDX_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else if (status_en) begin
      done_q <= wr_data_i[DONE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eop_q <= 1'b0;
      len_q <= '0;
    end else if (ctrl_en) begin
      eop_q <= wr_data_i[EOP_BIT];
      len_q <= wr_data_i[LEN_W-1:0];
    end
  end

  // both 64-bit pointers are assembled word by word from consecutive slots
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      link_q <= '0;
    end else if (wr_en_i) begin
      for (int h = 0; h < PTR_WORDS; h++) begin
        if (wr_idx_i == IDX_W'(IDX_SRC_LO + h))  src_q[h*WORD_W +: WORD_W]  <= wr_data_i;
        if (wr_idx_i == IDX_W'(IDX_LINK_LO + h)) link_q[h*WORD_W +: WORD_W] <= wr_data_i;
      end
    end
  end

  assign done_o      = done_q;
  assign eop_o       = eop_q;
  assign len_m1_o    = len_q;
  assign src_addr_o  = src_q;
  assign link_addr_o = link_q;
endmodule

// File: rtl/sg_stream_out.sv
module sg_stream_out
  import sg_pkg::*;
#(
  parameter int PTR_W = 64,
  parameter int LEN_W = 26,
  parameter int CNT_W = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_desc_i,
  input  logic [PTR_W-1:0]  src_addr_i,
  input  logic [LEN_W-1:0]  len_m1_i,
  input  logic              eop_i,
  input  logic              load_word_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              send_i,
  input  logic              tready_i,
  output logic [BYTE_W-1:0] tdata_o,
  output logic              tvalid_o,
  output logic              tlast_o,
  output logic              fire_o,
  output logic              last_byte_o,
  output logic              lane_end_o,
  output logic [PTR_W-3:0]  rd_word_addr_o,
  output logic [CNT_W-1:0]  sent_o
);
  logic [PTR_W-1:0]  src_q, src_d;
  logic [CNT_W-1:0]  remain_q, remain_d;
  logic [CNT_W-1:0]  sent_q, sent_d;
  logic [WORD_W-1:0] word_q;
  logic [BYTE_W-1:0] lane_byte [LANES];
  logic [LANE_W-1:0] lane;
  logic              ptr_en;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_byte[l] = word_q[l*BYTE_W +: BYTE_W];
  end

  assign lane           = src_q[LANE_W-1:0];
  assign fire_o         = send_i && tready_i;
  assign tvalid_o       = send_i;
  assign tdata_o        = lane_byte[lane];
  assign last_byte_o    = (remain_q == CNT_W'(1));
  assign tlast_o        = eop_i && last_byte_o;
  assign lane_end_o     = (lane == {LANE_W{1'b1}});
  assign rd_word_addr_o = src_q[PTR_W-1:2];
  assign sent_o         = sent_q;
  assign ptr_en         = load_desc_i || fire_o;

  always_comb begin
    src_d    = src_q;
    remain_d = remain_q;
    sent_d   = sent_q;
    if (load_desc_i) begin
      src_d    = src_addr_i;
      remain_d = CNT_W'(len_m1_i) + CNT_W'(1);
      sent_d   = '0;
    end else if (fire_o) begin
      src_d    = src_q + PTR_W'(1);
      remain_d = remain_q - CNT_W'(1);
      sent_d   = sent_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q    <= '0;
      remain_q <= '0;
      sent_q   <= '0;
    end else if (ptr_en) begin
      src_q    <= src_d;
      remain_q <= remain_d;
      sent_q   <= sent_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (load_word_i) begin
      word_q <= word_i;
    end
  end

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tvalid_o && !tready_i |=> tvalid_o && $stable(tdata_o) && $stable(tlast_o));

  assert_no_underrun_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> remain_q != '0);
endmodule

// File: rtl/sg_walk_ctrl.sv
module sg_walk_ctrl
  import sg_pkg::*;
#(
  parameter int PTR_W = 64,
  parameter int CNT_W = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [PTR_W-1:0]  head_ptr_i,
  input  logic              mem_resp_i,
  input  logic              mem_err_i,
  input  logic              desc_done_i,
  input  logic [PTR_W-1:0]  link_addr_i,
  input  logic [PTR_W-3:0]  rd_word_addr_i,
  input  logic              fire_i,
  input  logic              last_byte_i,
  input  logic              lane_end_i,
  input  logic [CNT_W-1:0]  sent_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [PTR_W-3:0]  mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic              desc_wr_o,
  output logic [IDX_W-1:0]  desc_idx_o,
  output logic              load_desc_o,
  output logic              load_word_o,
  output logic              send_o,
  output logic              busy_o,
  output logic              idle_o,
  output logic              error_o
);
  localparam int AW    = PTR_W - 2;
  localparam int PAD_W = WORD_W - 1 - CNT_W;

  walk_state_t      state_q, state_d;
  logic [IDX_W-1:0] widx_q, widx_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             err_q, err_d;
  logic [AW-1:0]    desc_base;

  assign desc_base = ptr_q[PTR_W-1:2];

  always_comb begin
    state_d     = state_q;
    widx_d      = widx_q;
    ptr_d       = ptr_q;
    err_d       = err_q;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = desc_base;
    mem_wdata_o = {1'b1, {PAD_W{1'b0}}, sent_i};
    desc_wr_o   = 1'b0;
    load_desc_o = 1'b0;
    load_word_o = 1'b0;
    send_o      = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          state_d = S_FETCH;
          ptr_d   = head_ptr_i;
          widx_d  = '0;
          err_d   = 1'b0;
        end
      end
      S_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = desc_base + AW'(widx_q);
        if (mem_resp_i) begin
          if (mem_err_i) begin
            err_d   = 1'b1;
            state_d = S_IDLE;
          end else begin
            desc_wr_o = 1'b1;
            if (widx_q == IDX_LAST) state_d = S_DECIDE;
            else                    widx_d  = widx_q + IDX_W'(1);
          end
        end
      end
      S_DECIDE: begin
        if (desc_done_i) begin
          state_d = S_IDLE;
        end else begin
          load_desc_o = 1'b1;
          state_d     = S_READ;
        end
      end
      S_READ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = rd_word_addr_i;
        if (mem_resp_i) begin
          if (mem_err_i) begin
            err_d   = 1'b1;
            state_d = S_IDLE;
          end else begin
            load_word_o = 1'b1;
            state_d     = S_SEND;
          end
        end
      end
      S_SEND: begin
        send_o = 1'b1;
        if (fire_i) begin
          if (last_byte_i)     state_d = S_WBACK;
          else if (lane_end_i) state_d = S_READ;
        end
      end
      S_WBACK: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        if (mem_resp_i) begin
          if (mem_err_i) begin
            err_d   = 1'b1;
            state_d = S_IDLE;
          end else begin
            ptr_d   = link_addr_i;
            widx_d  = '0;
            state_d = S_FETCH;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      widx_q  <= '0;
      ptr_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      widx_q  <= widx_d;
      ptr_q   <= ptr_d;
      err_q   <= err_d;
    end
  end

  assign desc_idx_o = widx_q;
  assign idle_o     = (state_q == S_IDLE);
  assign busy_o     = !idle_o;
  assign error_o    = err_q;

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_resp_i |=> mem_req_o && $stable(mem_addr_o)
                                 && $stable(mem_we_o) && $stable(mem_wdata_o));

  assert_wb_done_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_we_o |-> mem_wdata_o[DONE_BIT]);

  assert_err_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_resp_i && mem_err_i |=> idle_o && error_o);

  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> !mem_req_o && !send_o);

  assert_start_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o && start_i |=> busy_o);
endmodule

// File: rtl/sg_chain_engine.sv
module sg_chain_engine
  import sg_pkg::*;
#(
  parameter int PTR_W = 64,
  parameter int LEN_W = 26,
  parameter int CNT_W = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [PTR_W-1:0]  head_ptr_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [PTR_W-3:0]  mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_resp_i,
  input  logic              mem_err_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              m_tvalid_o,
  input  logic              m_tready_i,
  output logic [BYTE_W-1:0] m_tdata_o,
  output logic              m_tlast_o,
  output logic              busy_o,
  output logic              idle_o,
  output logic              error_o
);
  logic             desc_wr, load_desc, load_word, send;
  logic [IDX_W-1:0] desc_idx;
  logic             desc_done, desc_eop;
  logic [LEN_W-1:0] desc_len_m1;
  logic [PTR_W-1:0] desc_src, desc_link;
  logic             fire, last_byte, lane_end;
  logic [PTR_W-3:0] rd_word_addr;
  logic [CNT_W-1:0] sent;

  sg_desc_store #(.PTR_W(PTR_W), .LEN_W(LEN_W)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (desc_wr),
    .wr_idx_i    (desc_idx),
    .wr_data_i   (mem_rdata_i),
    .done_o      (desc_done),
    .eop_o       (desc_eop),
    .len_m1_o    (desc_len_m1),
    .src_addr_o  (desc_src),
    .link_addr_o (desc_link)
  );

  sg_stream_out #(.PTR_W(PTR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_stream (
    .clk            (clk),
    .rst_n          (rst_n),
    .load_desc_i    (load_desc),
    .src_addr_i     (desc_src),
    .len_m1_i       (desc_len_m1),
    .eop_i          (desc_eop),
    .load_word_i    (load_word),
    .word_i         (mem_rdata_i),
    .send_i         (send),
    .tready_i       (m_tready_i),
    .tdata_o        (m_tdata_o),
    .tvalid_o       (m_tvalid_o),
    .tlast_o        (m_tlast_o),
    .fire_o         (fire),
    .last_byte_o    (last_byte),
    .lane_end_o     (lane_end),
    .rd_word_addr_o (rd_word_addr),
    .sent_o         (sent)
  );

  sg_walk_ctrl #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .head_ptr_i     (head_ptr_i),
    .mem_resp_i     (mem_resp_i),
    .mem_err_i      (mem_err_i),
    .desc_done_i    (desc_done),
    .link_addr_i    (desc_link),
    .rd_word_addr_i (rd_word_addr),
    .fire_i         (fire),
    .last_byte_i    (last_byte),
    .lane_end_i     (lane_end),
    .sent_i         (sent),
    .mem_req_o      (mem_req_o),
    .mem_we_o       (mem_we_o),
    .mem_addr_o     (mem_addr_o),
    .mem_wdata_o    (mem_wdata_o),
    .desc_wr_o      (desc_wr),
    .desc_idx_o     (desc_idx),
    .load_desc_o    (load_desc),
    .load_word_o    (load_word),
    .send_o         (send),
    .busy_o         (busy_o),
    .idle_o         (idle_o),
    .error_o        (error_o)
  );
endmodule

// File: tb/test_sg_chain_engine.sv
`timescale 1ns/1ps
module test_sg_chain_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] head_ptr_i = '0;
  logic        mem_req_o, mem_we_o;
  logic [61:0] mem_addr_o;
  logic [31:0] mem_wdata_o;
  logic        mem_resp_i = 1'b0;
  logic        mem_err_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        m_tvalid_o;
  logic        m_tready_i = 1'b0;
  logic [7:0]  m_tdata_o;
  logic        m_tlast_o;
  logic        busy_o, idle_o, error_o;

  always #4 clk = ~clk;

  sg_chain_engine i_sg_chain_engine (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .head_ptr_i(head_ptr_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_resp_i(mem_resp_i), .mem_err_i(mem_err_i),
    .mem_rdata_i(mem_rdata_i), .m_tvalid_o(m_tvalid_o), .m_tready_i(m_tready_i),
    .m_tdata_o(m_tdata_o), .m_tlast_o(m_tlast_o), .busy_o(busy_o),
    .idle_o(idle_o), .error_o(error_o)
  );

  logic [31:0] mem [4096];
  int          total = 0;
  int          bad = 0;
  bit          finished = 0;

  logic [7:0]  exp_data [1024];
  bit          exp_last [1024];
  int          exp_n = 0;
  int          got_n = 0;
  int          wb_idx [32];
  logic [31:0] wb_val [32];
  int          wb_n = 0;
  logic [61:0] log_addr [64];
  bit          log_we [64];
  int          log_n = 0;
  int          wr_n = 0;
  int          hold_bad = 0;
  bit          err_armed = 0;
  logic [61:0] err_word = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // memory responder: zero to two wait cycles, one-cycle response
  initial begin
    forever begin
      @(negedge clk);
      if (mem_resp_i) begin
        mem_resp_i = 1'b0;
        mem_err_i  = 1'b0;
        continue;
      end
      if (!mem_req_o) continue;
      begin
        logic [61:0] a;
        logic        we;
        logic [31:0] wd;
        int          dly;
        a   = mem_addr_o;
        we  = mem_we_o;
        wd  = mem_wdata_o;
        dly = int'($urandom % 3);
        for (int d = 0; d < dly; d++) begin
          @(negedge clk);
          if (!mem_req_o || mem_addr_o != a || mem_we_o != we || mem_wdata_o != wd) hold_bad++;
        end
        if (log_n < 64) begin
          log_addr[log_n] = a;
          log_we[log_n]   = we;
        end
        log_n++;
        if (err_armed && a == err_word) begin
          mem_err_i = 1'b1;
        end else if (we) begin
          mem[int'(a[11:0])] = wd;
          wr_n++;
        end else begin
          mem_rdata_i = mem[int'(a[11:0])];
        end
        mem_resp_i = 1'b1;
      end
    end
  end

  // stream sink and monitor
  initial begin
    bit          stall_prev;
    logic [7:0]  prev_d;
    logic        prev_l;
    stall_prev = 0;
    prev_d = '0;
    prev_l = 0;
    forever begin
      @(negedge clk);
      m_tready_i = (($urandom % 10) < 7);
      #1;
      if (stall_prev) begin
        chk(m_tvalid_o && m_tdata_o == prev_d && m_tlast_o == prev_l, "R7 stall hold",
            {55'd0, m_tvalid_o, m_tdata_o}, {55'd1, prev_d});
      end
      if (m_tvalid_o && m_tready_i) begin
        if (got_n < exp_n) begin
          chk(m_tdata_o == exp_data[got_n], "R5 byte value", 64'(m_tdata_o), 64'(exp_data[got_n]));
          chk(m_tlast_o == exp_last[got_n], "R6 tlast", 64'(m_tlast_o), 64'(exp_last[got_n]));
        end else begin
          chk(0, "R4 extra byte", 64'(got_n), 64'(exp_n));
        end
        got_n++;
      end
      stall_prev = m_tvalid_o && !m_tready_i;
      prev_d = m_tdata_o;
      prev_l = m_tlast_o;
    end
  end

  task automatic build_expect(input logic [63:0] head);
    logic [63:0] p;
    logic [63:0] a;
    int          w, len;
    bit          eop;
    p = head; exp_n = 0; wb_n = 0;
    for (int k = 0; k < 16; k++) begin
      w = int'((p >> 2) & 64'hFFF);
      if (mem[w][31]) break;
      len = int'(mem[(w+1)%4096][25:0]) + 1;
      eop = mem[(w+1)%4096][30];
      a = {mem[(w+3)%4096], mem[(w+2)%4096]};
      for (int i = 0; i < len; i++) begin
        logic [63:0] b;
        b = a + 64'(i);
        exp_data[exp_n] = mem[int'((b >> 2) & 64'hFFF)][8*int'(b[1:0]) +: 8];
        exp_last[exp_n] = eop && (i == len - 1);
        exp_n++;
      end
      wb_idx[wb_n] = w;
      wb_val[wb_n] = 32'h8000_0000 | 32'(len);
      wb_n++;
      p = {mem[(w+7)%4096], mem[(w+6)%4096]};
    end
  endtask

  task automatic put_desc(input logic [63:0] at, input logic [31:0] st, input logic [31:0] ctl,
                          input logic [63:0] src, input logic [63:0] nxt);
    int w;
    w = int'((at >> 2) & 64'hFFF);
    mem[w]   = st;
    mem[w+1] = ctl;
    mem[w+2] = src[31:0];
    mem[w+3] = src[63:32];
    mem[w+4] = $urandom;
    mem[w+5] = $urandom;
    mem[w+6] = nxt[31:0];
    mem[w+7] = nxt[63:32];
  endtask

  task automatic run_chain(input logic [63:0] head, input bit expect_err,
                           input bit poke, input logic [63:0] poke_head);
    bit went_idle;
    build_expect(head);
    if (expect_err) begin
      exp_n = 0;
      wb_n = 0;
    end
    got_n = 0; log_n = 0; wr_n = 0; hold_bad = 0;
    @(negedge clk);
    start_i = 1'b1;
    head_ptr_i = head;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o && !idle_o, "R13 busy after start", {busy_o, idle_o}, 2'b10);
    chk(!error_o, "R11 cleared by start", 64'(error_o), 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      chk(busy_o, "R10 still busy before poke", 64'(busy_o), 1);
      start_i = 1'b1;
      head_ptr_i = poke_head;
      @(negedge clk);
      start_i = 1'b0;
    end
    went_idle = 0;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (idle_o) begin
        went_idle = 1;
        break;
      end
    end
    chk(went_idle, "R13 returns idle", 64'(went_idle), 1);
    repeat (2) @(negedge clk);
    chk(error_o == expect_err, "R11 error flag", 64'(error_o), 64'(expect_err));
    chk(got_n == exp_n, "R4 byte count", 64'(got_n), 64'(exp_n));
    for (int i = 0; i < wb_n; i++)
      chk(mem[wb_idx[i]] == wb_val[i], "R8 status write-back", 64'(mem[wb_idx[i]]), 64'(wb_val[i]));
    chk(wr_n == wb_n, "R8 write count", 64'(wr_n), 64'(wb_n));
    chk(hold_bad == 0, "R12 request hold", 64'(hold_bad), 0);
    chk(!m_tvalid_o && !mem_req_o && busy_o == !idle_o, "R13 idle quiet",
        {m_tvalid_o, mem_req_o}, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 4096; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(idle_o && !busy_o && !error_o && !m_tvalid_o && !mem_req_o, "R1 reset state",
        {idle_o, busy_o, error_o, m_tvalid_o, mem_req_o}, 5'b10000);

    // directed: two descriptors, 64-bit link with nonzero upper word, terminator
    put_desc(64'h100, 32'h0000_1234, 32'hBC00_0009, 64'h1001, 64'h1_0000_0140);
    put_desc(64'h140, 32'h7800_0000, 32'h0000_0000, 64'h1103, 64'h180);
    put_desc(64'h180, 32'h8000_0000, 32'h4000_0003, 64'h1200, 64'h100);
    run_chain(64'h100, 0, 0, 0);
    for (int k = 0; k < 8; k++)
      chk(log_addr[k] == 62'h40 + 62'(k) && !log_we[k], "R2 fetch order", 64'(log_addr[k]), 64'h40 + 64'(k));
    begin
      bit found;
      found = 0;
      for (int k = 0; k < 64 && k < log_n; k++)
        if (log_addr[k] == 62'h4000_0050 && !log_we[k]) found = 1;
      chk(found, "R9 upper pointer word", 64'(found), 1);
    end
    chk(exp_n == 11, "R4 directed length", 64'(exp_n), 11);

    // already-completed head
    run_chain(64'h183, 0, 0, 0);
    chk(got_n == 0 && wr_n == 0 && log_n == 8, "R3 completed head", {got_n[15:0], wr_n[15:0], log_n[15:0]}, 64'h8);
    chk(mem[96] == 32'h8000_0000, "R3 status untouched", 64'(mem[96]), 64'h8000_0000);

    // start while busy, lane wrap, tlast set
    put_desc(64'h200, 32'h0, 32'h4000_000B, 64'h1202, 64'h180);
    put_desc(64'h300, 32'h0, 32'h4000_0003, 64'h1300, 64'h180);
    run_chain(64'h200, 0, 1, 64'h300);
    chk(mem[192] == 32'h0, "R10 ignored start", 64'(mem[192]), 0);

    // error on a payload read, then recovery
    put_desc(64'h500, 32'h0000_0055, 32'h0000_0004, 64'h1500, 64'h180);
    err_word = 62'h540;
    err_armed = 1;
    run_chain(64'h500, 1, 0, 0);
    chk(mem[320] == 32'h0000_0055, "R11 no write-back on error", 64'(mem[320]), 64'h55);
    repeat (5) @(negedge clk);
    chk(error_o, "R11 sticky", 64'(error_o), 1);
    err_armed = 0;
    run_chain(64'h500, 0, 0, 0);

    // random chains
    for (int it = 0; it < 30; it++) begin
      int n;
      n = 1 + int'($urandom % 4);
      for (int d = 0; d < n; d++) begin
        logic [31:0] ctl;
        ctl = ($urandom & 32'hFC00_0000 & ~32'h8000_0000) | ($urandom % 32);
        put_desc(64'h400 + 64'(d * 32), $urandom & 32'h7FFF_FFFF, ctl,
                 64'h2000 + 64'(d * 256) + 64'($urandom % 4), 64'h400 + 64'((d + 1) * 32));
      end
      put_desc(64'h400 + 64'(n * 32), 32'h8000_0000 | $urandom, $urandom, 64'h2000, 64'h100);
      run_chain(64'h400, 0, 0, 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R13 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule